// File: doc/BRIEF.md
# Word Divide Unit with Flags

This block executes the word-size divide operations of a 32-bit processor core. A 32-bit dividend, read by the surrounding pipeline from a data register, is divided by a 16-bit divisor. The operation is unsigned or signed, chosen per operation. The unit does not touch the register file. When it finishes, it presents a packed result, a write-enable for the destination register, the four arithmetic condition flags and a strobe that requests a divide-by-zero trap. The core uses these to update its state.

An operation begins with a one-cycle `start` while the unit is idle. `busy` stays high until the operation retires. `done` marks the single cycle in which the outputs are valid. The core feeds in the current negative flag as `prevN`, so that an overflowing divide can leave that flag untouched. The divide is a one-bit-per-cycle restoring loop on operand magnitudes, followed by a sign fix-up.

Top module: `word_divider`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` stays high from the accepting edge until `done`. `done` is high for exactly one cycle per accepted operation. A `start` while busy is ignored and produces no further `done`.
- R2: With a nonzero divisor, `done` is high after the 32nd rising edge following the edge that accepted `start`. With a zero divisor, `done` is high right after the accepting edge.
- R3: A zero divisor gives `divZeroExc`=1 with `done`, `regWrEn`=0, V=0, Z=0, C=0, and N equal to `prevN`.
- R4: In unsigned mode (`signedMode`=0) the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor. On success, `result[31:16]` holds the remainder and `result[15:0]` holds the quotient.
- R5: In unsigned mode, overflow occurs exactly when the quotient exceeds 0xFFFF.
- R6: In signed mode (`signedMode`=1) both operands are two's complement. The quotient truncates toward zero, the remainder has the sign of the dividend, and the packing is the same as in R4.
- R7: In signed mode, overflow occurs exactly when the quotient lies outside -32768..32767.
- R8: On overflow, V=1, Z=0, N equals `prevN`, and `regWrEn`=0.
- R9: On success, `regWrEn`=1, N is bit 15 of the quotient, Z is 1 exactly when the 16-bit quotient is zero, and V=0.
- R10: C is 0 in every `done` cycle, including overflow and divide-by-zero.
- R11: After reset, `busy`, `done`, `regWrEn` and `divZeroExc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| signedMode | input | 1 | 1 = two's complement, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled at the accepting edge |
| divisor | input | 16 | Divisor, sampled at the accepting edge |
| prevN | input | 1 | Current N flag of the core, passed through when N must not change |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe; the outputs below are valid |
| regWrEn | output | 1 | Write `result` to the destination register |
| result | output | 32 | {remainder, quotient} |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag (always 0) |
| divZeroExc | output | 1 | Divide-by-zero trap request |

## Verification
The embedded properties check the outcome rules on every cycle. No more than one of write, trap and overflow is active at a time. An overflow keeps N and clears Z. A trap suppresses the write. `done` never lasts two cycles, and an accepted start leads into the correct state. Only the bench's scenarios can show that the numbers are right and that the 32-cycle latency holds. These scenarios cover the unsigned and signed quotient and remainder values, the exact overflow boundaries (0xFFFF against 0x10000, and -32768 against +32768), the most negative dividend divided by -1, and a start pulse ignored in mid-operation.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } divState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture operands, prepare magnitudes
    logic step;   // one restoring iteration
    logic fin;    // outputs valid this cycle
  } dpCtl_t;
endpackage

// File: rtl/wdiv_ctrl.sv
module wdiv_ctrl
  import wdiv_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   dvsZero,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int CNT_W = $clog2(ITER);

  divState_e        state;
  logic [CNT_W-1:0] iterCnt;
  logic             lastIter;

  assign lastIter = (iterCnt == CNT_W'(ITER - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= dvsZero ? ST_DONE : ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (lastIter) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_RUN);
    ctl.fin  = (state == ST_DONE);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // R1: done is a single-cycle strobe
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R1: start while busy does not restart the iteration count
  p_busy_ignore_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && !lastIter) |=> (state == ST_RUN && iterCnt != '0));
  // R2: accepted start with nonzero divisor enters the iteration phase
  p_start_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !dvsZero) |=> (state == ST_RUN && iterCnt == '0));
  // R2: zero divisor finishes at once
  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && dvsZero) |=> done);
  // R2: last iteration is followed by done
  p_last_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && lastIter) |=> done);
endmodule

// File: rtl/wdiv_dpath.sv
module wdiv_dpath
  import wdiv_pkg::*;
#(
  parameter int DVS_W = 16,
  parameter int DVD_W = 2 * DVS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             signedMode,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  input  logic             prevN,
  output logic             dvsZero,
  output logic             regWrEn,
  output logic [DVD_W-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC,
  output logic             divZeroExc
);
  // operand magnitudes
  logic             dvdNeg, dvsNeg;
  logic [DVD_W-1:0] dvdMag;
  logic [DVS_W-1:0] dvsMag;

  assign dvsZero = (divisor == '0);
  assign dvdNeg  = signedMode & dividend[DVD_W-1];
  assign dvsNeg  = signedMode & divisor[DVS_W-1];
  assign dvdMag  = dvdNeg ? (~dividend + 1'b1) : dividend;
  assign dvsMag  = dvsNeg ? (~divisor + 1'b1) : divisor;

  // iteration state
  logic [DVD_W-1:0] quoR;
  logic [DVS_W-1:0] remR;
  logic [DVS_W-1:0] dvsMagR;
  logic             quoNegR, remNegR, sgnR, dzR;

  logic [DVS_W:0]   shifted, trial;
  logic             fits;

  assign shifted = {remR, quoR[DVD_W-1]};
  assign trial   = shifted - {1'b0, dvsMagR};
  assign fits    = ~trial[DVS_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR    <= '0;
      remR    <= '0;
      dvsMagR <= '0;
      quoNegR <= 1'b0;
      remNegR <= 1'b0;
      sgnR    <= 1'b0;
      dzR     <= 1'b0;
    end else if (ctl.load) begin
      quoR    <= dvdMag;
      remR    <= '0;
      dvsMagR <= dvsMag;
      quoNegR <= dvdNeg ^ dvsNeg;
      remNegR <= dvdNeg;
      sgnR    <= signedMode;
      dzR     <= dvsZero;
    end else if (ctl.step) begin
      remR <= fits ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
      quoR <= {quoR[DVD_W-2:0], fits};
    end
  end

  // range check and sign fix-up
  logic             quoHi, ovfU, ovfS, ovf, ok;
  logic [DVS_W-1:0] quoLo, remOut;

  assign quoHi = |quoR[DVD_W-1:DVS_W];
  assign ovfU  = quoHi;
  // magnitude limit: 2^(W-1) for a negative quotient, 2^(W-1)-1 otherwise
  assign ovfS  = quoHi | (quoR[DVS_W-1] & (~quoNegR | (|quoR[DVS_W-2:0])));
  assign ovf   = sgnR ? ovfS : ovfU;

  assign quoLo  = quoNegR ? (~quoR[DVS_W-1:0] + 1'b1) : quoR[DVS_W-1:0];
  assign remOut = remNegR ? (~remR + 1'b1) : remR;

  assign ok         = ctl.fin & ~dzR & ~ovf;
  assign regWrEn    = ok;
  assign divZeroExc = ctl.fin & dzR;
  assign result     = {remOut, quoLo};
  assign flagV      = ctl.fin & ~dzR & ovf;
  assign flagZ      = ok & (quoLo == '0);
  assign flagN      = ok ? quoLo[DVS_W-1] : prevN;
  assign flagC      = 1'b0;

  // R8: write, trap and overflow are mutually exclusive
  p_outcome_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, divZeroExc, flagV}));
  // R8: overflow keeps N and clears Z
  p_ovf_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagV |-> (flagN == prevN && !flagZ));
  // R3: trap keeps N and clears Z
  p_dz_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    divZeroExc |-> (flagN == prevN && !flagZ && !flagV));
  // R9: a write carries the quotient sign into N
  p_write_n_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (flagN == result[DVS_W-1] && !flagV));
endmodule

// File: rtl/word_divider.sv
module word_divider
  import wdiv_pkg::*;
#(
  parameter int DVS_W = 16,
  localparam int DVD_W = 2 * DVS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  input  logic             prevN,
  output logic             busy,
  output logic             done,
  output logic             regWrEn,
  output logic [DVD_W-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC,
  output logic             divZeroExc
);
  dpCtl_t ctl;
  logic   dvsZero;

  wdiv_ctrl #(.ITER(DVD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dvsZero(dvsZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  wdiv_dpath #(.DVS_W(DVS_W), .DVD_W(DVD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .prevN(prevN),
    .dvsZero(dvsZero), .regWrEn(regWrEn), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .divZeroExc(divZeroExc)
  );

  // R10: C never set while outputs are valid
  p_c_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !flagC);
  // R1: outcome outputs only with done
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!regWrEn && !divZeroExc && !flagV));
endmodule

// File: tb/test_word_divider.sv
module test_word_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        prevN = 1'b0;
  logic        busy, done, regWrEn, flagN, flagZ, flagV, flagC, divZeroExc;
  logic [31:0] result;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int doneSeen = 0;

  typedef struct {
    logic        wr;
    logic        dz;
    logic [31:0] res;
    logic        n, z, v;
    int          lat;
    int          startCyc;
    string       tag;
  } expItem_t;

  expItem_t scb[$];

  word_divider i_word_divider (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .prevN(prevN),
    .busy(busy), .done(done), .regWrEn(regWrEn), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .divZeroExc(divZeroExc)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit cond, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic sgn, input logic [31:0] a,
                                     input logic [15:0] b, input logic pn,
                                     input string tag);
    expItem_t e;
    longint q, r;
    bit ov;
    e.tag = tag; e.res = '0; e.dz = 1'b0;
    if (b == 16'd0) begin
      e.dz = 1'b1; e.wr = 1'b0; e.n = pn; e.z = 1'b0; e.v = 1'b0; e.lat = 0;
      return e;
    end
    e.lat = 32;
    if (sgn) begin
      q = longint'($signed(a)) / longint'($signed(b));
      r = longint'($signed(a)) % longint'($signed(b));
      ov = (q > 32767) || (q < -32768);
    end else begin
      q = longint'(a) / longint'(b);
      r = longint'(a) % longint'(b);
      ov = (q > 65535);
    end
    if (ov) begin
      e.wr = 1'b0; e.v = 1'b1; e.z = 1'b0; e.n = pn;
    end else begin
      e.wr = 1'b1; e.v = 1'b0;
      e.res = {r[15:0], q[15:0]};
      e.n = q[15];
      e.z = (q[15:0] == 16'd0);
    end
    return e;
  endfunction

  // monitor: compare each done cycle with the oldest expected item
  always @(negedge clk) begin
    if (rstN && done) begin
      doneSeen++;
      if (scb.size() == 0) begin
        chk(1'b0, "R1", "unexpected done", 1, 0);
      end else begin
        expItem_t e;
        e = scb.pop_front();
        chk(cyc - e.startCyc == e.lat, "R2", {e.tag, " latency"}, cyc - e.startCyc, e.lat);
        chk(regWrEn == e.wr, e.wr ? "R9" : "R8", {e.tag, " regWrEn"}, regWrEn, e.wr);
        chk(divZeroExc == e.dz, "R3", {e.tag, " divZeroExc"}, divZeroExc, e.dz);
        chk(flagV == e.v, e.v ? "R8" : "R9", {e.tag, " V"}, flagV, e.v);
        chk(flagZ == e.z, e.wr ? "R9" : "R8", {e.tag, " Z"}, flagZ, e.z);
        chk(flagN == e.n, e.wr ? "R9" : "R8", {e.tag, " N"}, flagN, e.n);
        chk(flagC == 1'b0, "R10", {e.tag, " C"}, flagC, 0);
        if (e.wr) chk(result == e.res, e.tag, "result", result, e.res);
      end
    end
  end

  // driver: issue one operation, optionally poke start mid-run
  task automatic doOp(input logic sgn, input logic [31:0] a, input logic [15:0] b,
                      input logic pn, input string tag, input bit poke);
    expItem_t e;
    int seen0;
    @(negedge clk);
    signedMode = sgn; dividend = a; divisor = b; prevN = pn; start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    e = model(sgn, a, b, pn, tag);
    e.startCyc = cyc;
    scb.push_back(e);
    seen0 = doneSeen;
    if (poke) begin
      repeat (3) @(negedge clk);
      signedMode = ~sgn; dividend = ~a; divisor = b + 16'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 100 && doneSeen == seen0; i++) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy, "R1", {tag, " done single cycle"}, done, 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(doneSeen == seen0 + 1, "R1", "start while busy ignored", doneSeen - seen0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !regWrEn && !divZeroExc, "R11", "reset outputs",
        {busy, done, regWrEn, divZeroExc}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after reset", {busy, done}, 0);

    // unsigned (R4, R5)
    doOp(1'b0, 32'd100, 16'd7, 1'b0, "R4 100/7", 1'b0);
    doOp(1'b0, 32'h000FFFF0, 16'h0010, 1'b0, "R5 q=FFFF", 1'b0);
    doOp(1'b0, 32'h00100000, 16'h0010, 1'b1, "R5 q=10000", 1'b0);
    doOp(1'b0, 32'hFFFFFFFF, 16'hFFFF, 1'b0, "R5 max/max", 1'b0);
    doOp(1'b0, 32'd5, 16'd10, 1'b1, "R9 zero quotient", 1'b0);
    doOp(1'b0, 32'h12345678, 16'h8001, 1'b0, "R4 wide divisor", 1'b0);
    // divide by zero (R3)
    doOp(1'b0, 32'd77, 16'd0, 1'b1, "R3 unsigned dz", 1'b0);
    doOp(1'b1, 32'hFFFFFFF0, 16'd0, 1'b0, "R3 signed dz", 1'b0);
    // signed (R6, R7)
    doOp(1'b1, -32'sd100, 16'sd7, 1'b0, "R6 -100/7", 1'b0);
    doOp(1'b1, 32'sd100, -16'sd7, 1'b1, "R6 100/-7", 1'b0);
    doOp(1'b1, -32'sd7, -16'sd2, 1'b0, "R6 -7/-2", 1'b0);
    doOp(1'b1, -32'sd32768, 16'sd1, 1'b0, "R7 q=-32768", 1'b0);
    doOp(1'b1, 32'sd32767, 16'sd1, 1'b1, "R7 q=32767", 1'b0);
    doOp(1'b1, 32'sd32768, 16'sd1, 1'b0, "R7 q=32768", 1'b0);
    doOp(1'b1, -32'sd32769, 16'sd1, 1'b0, "R7 q=-32769", 1'b0);
    doOp(1'b1, 32'h80000000, -16'sd1, 1'b1, "R7 min/-1", 1'b0);
    doOp(1'b1, 32'h80000000, 16'h8000, 1'b0, "R7 min/min", 1'b0);
    // start while busy (R1)
    doOp(1'b0, 32'd5000, 16'd9, 1'b0, "R1 poke", 1'b1);

    chk(scb.size() == 0, "R1", "all results retired", scb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule